// File: doc/BRIEF.md
# Sensor Sync and Strobe Generator

This block drives the frame sync output and the flash strobe output of an image sensor. The sync output can come from one of three sources, chosen by control bits. A one-shot request gives a single-cycle pulse. A hold request keeps sync high for back-to-back frames. An external request passes a synchronized copy of a sync pin through to the output.

The strobe output can be generated automatically from rolling-shutter timing events, or it can be forced high. Automatic strobe works only in single-frame rolling-shutter mode. It starts when all rows of the frame are integrating together. Its width is one of two settings: one row time, or the time until one row before readout of the first row. For the second setting the caller supplies a count of row times until readout. A row-time tick paces the count.

All outputs are registered. The register decode and the row timing engine that produce these inputs lie outside the block.

Top module: `sync_strobe_gen`

## Requirements
- R1: A synchronous active-high reset drives sync_out and strobe_out to 0 in the cycle after reset is sampled.
- R2: A 0-to-1 transition of sync_oneshot, sampled at a clock edge, makes sync_out high for exactly the next cycle. Holding sync_oneshot at 1 produces no further pulse. This applies when neither sync_hold nor sync_ext is set.
- R3: While sync_hold is 1 and sync_ext is 0, sync_out is 1 in the cycle after each such edge. When sync_hold clears, sync_out falls one cycle later, unless another source is active.
- R4: While sync_ext is 1, sync_out equals the level that sync_pin had three clock edges earlier, passed through a two-flop synchronizer and an output register. The external source takes precedence over the hold source, and the hold source takes precedence over the one-shot.
- R5: Automatic strobe is enabled only when strobe_auto = 1 and rolling_sf = 1. In any other case strobe_out stays 0 unless strobe_force is set, and any pulse in progress is cancelled.
- R6: With strobe_long = 0 when all_rows_int is sampled high, strobe_out rises in the next cycle. It stays high until the edge that samples the first row_tick after that event, and it falls in the cycle after that edge.
- R7: With strobe_long = 1 and rows_to_read = N >= 2 when all_rows_int is sampled high, strobe_out rises in the next cycle. It falls in the cycle after the edge that samples the (N-1)th following row_tick.
- R8: With strobe_long = 1 and rows_to_read <= 1 when all_rows_int is sampled high, no strobe pulse is produced, and any pulse in progress ends.
- R9: While strobe_force is 1, strobe_out is 1 one cycle later, whatever strobe_auto and strobe_long are. After strobe_force clears, strobe_out returns to the automatic state.
- R10: A new all_rows_int event during a pulse restarts that pulse with the strobe_long and rows_to_read values present at the new event. Changes to strobe_long during a pulse have no effect on that pulse. If all_rows_int and row_tick arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_oneshot | input | 1 | One-shot sync request (rising edge detected) |
| sync_hold | input | 1 | Continuous sync request |
| sync_ext | input | 1 | Select the external sync pin as the source |
| strobe_auto | input | 1 | Enable automatic strobe |
| strobe_long | input | 1 | 0: one-row strobe; 1: strobe until one row before readout |
| strobe_force | input | 1 | Force strobe high |
| rolling_sf | input | 1 | Single-frame rolling-shutter mode flag |
| sync_pin | input | 1 | Asynchronous external sync pin |
| all_rows_int | input | 1 | One-cycle pulse: all rows start integrating |
| row_tick | input | 1 | One-cycle pulse per row time |
| rows_to_read | input | CNT_W | Row times from the all-rows event until first-row readout |
| sync_out | output | 1 | Frame sync output |
| strobe_out | output | 1 | Flash strobe output |

## Verification
The bench targets the points where a plausible design slips. A level-triggered one-shot would hold sync high while the request stays set. A wrong count load in long mode would make the strobe one row too long or too short, and would fire a pulse for counts of zero or one. Precedence mistakes would let the hold source override the external pin. Other cases are checked too: an all-rows event during a pulse, an event that lands together with a row tick, and mode changes that must cancel a pulse in progress. In each of these a faulty design leaves the strobe high for the wrong number of row ticks.

// File: rtl/sync_strobe_gen.sv
module sync_strobe_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_oneshot,
  input  logic             sync_hold,
  input  logic             sync_ext,
  input  logic             strobe_auto,
  input  logic             strobe_long,
  input  logic             strobe_force,
  input  logic             rolling_sf,
  input  logic             sync_pin,
  input  logic             all_rows_int,
  input  logic             row_tick,
  input  logic [CNT_W-1:0] rows_to_read,
  output logic             sync_out,
  output logic             strobe_out
);
  logic             pin_s1, pin_s2, oneshot_d, sync_q;
  logic             force_q, active, long_q;
  logic [CNT_W-1:0] cnt;

  wire auto_on   = strobe_auto & rolling_sf;
  wire long_ok   = rows_to_read > CNT_W'(1);
  wire oneshot_p = sync_oneshot & ~oneshot_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_s1    <= 1'b0;
      pin_s2    <= 1'b0;
      oneshot_d <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      pin_s1    <= sync_pin;
      pin_s2    <= pin_s1;
      oneshot_d <= sync_oneshot;
      sync_q    <= sync_ext ? pin_s2 : (sync_hold | oneshot_p);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= 1'b0;
      active  <= 1'b0;
      long_q  <= 1'b0;
      cnt     <= '0;
    end else begin
      force_q <= strobe_force;
      if (!auto_on) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (all_rows_int) begin
        long_q <= strobe_long;
        if (!strobe_long) begin
          active <= 1'b1;
          cnt    <= '0;
        end else if (long_ok) begin
          active <= 1'b1;
          cnt    <= rows_to_read - CNT_W'(1);
        end else begin
          active <= 1'b0;
          cnt    <= '0;
        end
      end else if (row_tick && active) begin
        if (!long_q || cnt == CNT_W'(1)) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  assign sync_out   = sync_q;
  assign strobe_out = force_q | active;
endmodule

module sync_strobe_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_oneshot,
  input logic             sync_hold,
  input logic             sync_ext,
  input logic             strobe_auto,
  input logic             strobe_long,
  input logic             strobe_force,
  input logic             rolling_sf,
  input logic             all_rows_int,
  input logic [CNT_W-1:0] rows_to_read,
  input logic             sync_out,
  input logic             strobe_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!sync_out && !strobe_out));
  // R2
  oneshot_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync_oneshot) && !sync_ext) |=> sync_out);
  // R3
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_hold && !sync_ext) |=> sync_out);
  // R5
  auto_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!(strobe_auto && rolling_sf) && !strobe_force) |=> !strobe_out);
  // R6
  strobe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (all_rows_int && strobe_auto && rolling_sf && (!strobe_long || rows_to_read > CNT_W'(1)))
      |=> strobe_out);
  // R8
  short_count_chk: assert property (@(posedge clk) disable iff (rst)
    (all_rows_int && strobe_auto && rolling_sf && strobe_long && rows_to_read <= CNT_W'(1)
      && !strobe_force) |=> !strobe_out);
  // R9
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_force |=> strobe_out);
endmodule

bind sync_strobe_gen sync_strobe_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sync_oneshot(sync_oneshot), .sync_hold(sync_hold),
  .sync_ext(sync_ext), .strobe_auto(strobe_auto), .strobe_long(strobe_long),
  .strobe_force(strobe_force), .rolling_sf(rolling_sf), .all_rows_int(all_rows_int),
  .rows_to_read(rows_to_read), .sync_out(sync_out), .strobe_out(strobe_out));

// File: tb/tb_sync_strobe_gen.sv
`timescale 1ns/1ps
module tb_sync_strobe_gen;
  localparam int CNT_W = 8;
  logic clk = 0, rst = 1;
  logic sr = 0, sa = 0, se = 0, sae = 0, saw = 0, sso = 0, sfrs = 0, pin = 0, evt = 0, tick = 0;
  logic [CNT_W-1:0] nrows = 0;
  logic sync_out, strobe_out;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string phase = "";

  always #2 clk = ~clk;

  sync_strobe_gen #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .sync_oneshot(sr), .sync_hold(sa), .sync_ext(se),
    .strobe_auto(sae), .strobe_long(saw), .strobe_force(sso), .rolling_sf(sfrs),
    .sync_pin(pin), .all_rows_int(evt), .row_tick(tick), .rows_to_read(nrows),
    .sync_out(sync_out), .strobe_out(strobe_out));

  // reference state, built from the requirements
  logic m_s1, m_s2, m_os, m_sync, m_force, m_act, m_long;
  int   m_cnt;

  function automatic logic next_sync(logic ext, logic hold, logic os, logic os_prev, logic s2);
    if (ext) return s2;
    if (hold) return 1'b1;
    return os & ~os_prev;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_os = 0; m_sync = 0; m_force = 0; m_act = 0; m_long = 0; m_cnt = 0;
    end else begin
      m_sync = next_sync(se, sa, sr, m_os, m_s2);
      m_os = sr; m_s2 = m_s1; m_s1 = pin;
      m_force = sso;
      if (!(sae && sfrs)) m_act = 0;
      else if (evt) begin
        m_long = saw;
        if (!saw) m_act = 1;
        else if (nrows >= 2) begin m_act = 1; m_cnt = int'(nrows) - 1; end
        else m_act = 0;
      end else if (tick && m_act) begin
        if (!m_long) m_act = 0;
        else begin m_cnt--; if (m_cnt == 0) m_act = 0; end
      end
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string ts, tt;
    ts = (phase != "") ? phase : (se ? "R4" : (sa ? "R3" : "R2"));
    tt = (phase != "") ? phase : (m_force ? "R9" : (!(sae && sfrs) ? "R5" : (m_long ? "R7" : "R6")));
    check({ts, " sync"}, sync_out, m_sync);
    check({tt, " strobe"}, strobe_out, m_force | m_act);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt = 0; tick = 0;
      @(negedge clk);
      compare();
    end
  endtask

  task automatic pulse_evt(int rows, logic lng);
    @(negedge clk); compare();
    nrows = CNT_W'(rows); saw = lng; evt = 1; tick = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); compare();
    evt = 0; tick = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1"; compare(); phase = "";
    // R2 one-shot held high
    sr = 1; step(4); sr = 0; step(2);
    // R3 / R4 precedence
    sa = 1; step(3); pin = 1; se = 1; step(4); pin = 0; step(4); se = 0; sa = 0; step(3);
    // R6 short strobe
    sae = 1; sfrs = 1;
    pulse_evt(5, 0); step(3); do_tick(); step(2);
    // R7 long strobe, 4 rows -> 3 ticks
    pulse_evt(4, 1);
    for (int k = 0; k < 4; k++) begin do_tick(); step(2); end
    // R8 counts zero and one
    phase = "R8";
    pulse_evt(1, 1); step(3); pulse_evt(0, 1); step(3);
    // R10 restart, saw flip mid-pulse, event with tick
    phase = "R10";
    pulse_evt(6, 1); do_tick(); step(1); saw = 0; pulse_evt(3, 1);
    tick = 1; step(1);
    for (int k = 0; k < 4; k++) begin do_tick(); step(1); end
    // R5 not rolling mode
    phase = "R5";
    sfrs = 0; pulse_evt(5, 0); step(3); sfrs = 1; sae = 1;
    pulse_evt(6, 1); step(1); sae = 0; step(2); sae = 1;
    // R9 force
    phase = "R9";
    sso = 1; step(4); pulse_evt(3, 1); step(2); sso = 0; step(2);
    phase = "";
    // random
    void'($urandom(32'h5eed1234));
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk); compare();
      evt  = ($urandom_range(0, 29) == 0);
      tick = ($urandom_range(0, 4) == 0);
      nrows = CNT_W'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) pin = ~pin;
      if ($urandom_range(0, 5) == 0) sr = ~sr;
      if ($urandom_range(0, 40) == 0) sa = ~sa;
      if ($urandom_range(0, 60) == 0) se = ~se;
      if ($urandom_range(0, 50) == 0) sae = ~sae;
      if ($urandom_range(0, 25) == 0) saw = ~saw;
      if ($urandom_range(0, 80) == 0) sso = ~sso;
      if ($urandom_range(0, 90) == 0) sfrs = ~sfrs;
    end
    @(negedge clk); compare();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule